// File: doc/BRIEF.md
# Speculative Load Address Tracker

This block lets a compiler place a load ahead of stores that may write the same memory. When the hoisted load issues, the pipeline allocates an entry that records the load's destination register tag and its address. Every store is snooped against all entries at once, and any entry whose 8-byte granule equals the store's granule is dropped. When the code reaches the point where the load originally sat, it issues a check for the destination register. The check reports a hit if the register's entry is still present, meaning no aliasing store intervened. It reports a miss if the entry is gone, and the core then branches to compiler-generated fix-up code.

The table is fully associative and has a parameterised number of entries (16 by default). An allocate for a register that is already tracked overwrites that register's entry. A new register takes the lowest-numbered free entry. When no entry is free, a round-robin pointer chooses the victim. A flush input empties the table in one cycle, for example on a context switch. Check responses are registered and arrive one cycle after the request.

Top module: `spec_load_tracker`

## Requirements
- R1: After reset every entry is invalid, `chk_done_o` is low, and any check of any tag returns a miss.
- R2: An allocate records its tag and address, and a check of that tag in any later cycle returns a hit if no killing store or flush has intervened.
- R3: `chk_done_o` is high exactly in the cycle after `chk_valid_i` was high. `chk_hit_o` reflects the table as it stood before that request cycle's allocate, store and flush took effect.
- R4: A store invalidates every valid entry whose granule matches, so several registers can be killed by one store.
- R5: Addresses are compared with bits [2:0] ignored. A store that differs from an entry only in those bits kills the entry, and a store that differs in bit 3 or above does not.
- R6: A check that hits leaves its entry in place, so a repeated check also hits.
- R7: An allocate for a tag that is already tracked replaces that entry's address. The old address no longer kills it, and the new one does, and one tag never occupies two entries.
- R8: An allocate for an untracked tag uses the lowest-numbered free entry. If the table is full, it evicts the entry at a round-robin pointer that starts at entry 0 after reset and advances by one (wrapping) only when an eviction happens.
- R9: `flush_i` invalidates all entries in one cycle and takes priority over an allocate in the same cycle.
- R10: When an allocate and a store to the same granule arrive in the same cycle, the store is applied first, so the new entry survives.
- R11: A check of a tag that was never allocated returns a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Invalidate the whole table |
| alloc_valid_i | input | 1 | Speculative load allocate request |
| alloc_tag_i | input | TAG_W | Destination register of the hoisted load |
| alloc_addr_i | input | ADDR_W | Address read by the hoisted load |
| store_valid_i | input | 1 | Store snoop request |
| store_addr_i | input | ADDR_W | Address written by the store |
| chk_valid_i | input | 1 | Check request |
| chk_tag_i | input | TAG_W | Register whose speculation is checked |
| chk_done_o | output | 1 | Check response valid, one cycle after request |
| chk_hit_o | output | 1 | 1 = entry present (speculation held), 0 = run fix-up |

## Verification
Directed sequences drive stores whose addresses match a tracked address exactly, differ from it only in bits [2:0], or differ from it in bit 3. These show whether the granule comparison is correct and whether one store kills every entry that matches. Other sequences re-allocate a tracked tag, fill all sixteen entries and then allocate twice more, and free one slot with a store. These separate in-place replacement, lowest-free placement and round-robin eviction. Same-cycle combinations (allocate with a store to the same granule, check with a killing store, flush with allocate) confirm the ordering rules. A long run of random traffic over small tag and address spaces is then compared every cycle against a behavioural model.

// File: rtl/slt_pkg.sv
package slt_pkg;
    localparam int unsigned SLT_ENTRIES  = 16;
    localparam int unsigned SLT_TAG_W    = 7;
    localparam int unsigned SLT_ADDR_W   = 48;
    localparam int unsigned SLT_GRAN_LSB = 3;
endpackage

// File: rtl/slt_match.sv
module slt_match #(
    parameter int unsigned N     = 16,
    parameter int unsigned TAG_W = 7,
    parameter int unsigned GW    = 45
) (
    input  logic [N-1:0]            valid_i,
    input  logic [N-1:0][TAG_W-1:0] tags_i,
    input  logic [N-1:0][GW-1:0]    grans_i,
    input  logic [GW-1:0]           store_gran_i,
    input  logic [TAG_W-1:0]        alloc_tag_i,
    input  logic [TAG_W-1:0]        chk_tag_i,
    output logic [N-1:0]            kill_o,
    output logic [N-1:0]            alloc_same_o,
    output logic [N-1:0]            chk_vec_o
);
    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign kill_o[i]       = valid_i[i] && (grans_i[i] == store_gran_i);
        assign alloc_same_o[i] = (tags_i[i] == alloc_tag_i);
        assign chk_vec_o[i]    = valid_i[i] && (tags_i[i] == chk_tag_i);
    end
endmodule

// File: rtl/slt_victim.sv
module slt_victim #(
    parameter int unsigned N     = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [N-1:0]     live_i,
    input  logic [N-1:0]     same_i,
    input  logic [IDX_W-1:0] ptr_i,
    output logic [IDX_W-1:0] idx_o,
    output logic             use_ptr_o
);
    always_comb begin
        logic found_free;
        logic found_same;
        found_free = 1'b0;
        found_same = 1'b0;
        idx_o      = ptr_i;
        for (int i = N - 1; i >= 0; i--) begin
            if (!live_i[i]) begin
                idx_o      = IDX_W'(i);
                found_free = 1'b1;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (live_i[i] && same_i[i]) begin
                idx_o      = IDX_W'(i);
                found_same = 1'b1;
            end
        end
        use_ptr_o = !found_free && !found_same;
    end
endmodule

// File: rtl/spec_load_tracker.sv
module spec_load_tracker
    import slt_pkg::*;
#(
    parameter int unsigned ENTRIES  = SLT_ENTRIES,
    parameter int unsigned TAG_W    = SLT_TAG_W,
    parameter int unsigned ADDR_W   = SLT_ADDR_W,
    parameter int unsigned GRAN_LSB = SLT_GRAN_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              alloc_valid_i,
    input  logic [TAG_W-1:0]  alloc_tag_i,
    input  logic [ADDR_W-1:0] alloc_addr_i,
    input  logic              store_valid_i,
    input  logic [ADDR_W-1:0] store_addr_i,
    input  logic              chk_valid_i,
    input  logic [TAG_W-1:0]  chk_tag_i,
    output logic              chk_done_o,
    output logic              chk_hit_o
);
    localparam int unsigned GW    = ADDR_W - GRAN_LSB;
    localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    typedef struct packed {
        logic             v;
        logic [TAG_W-1:0] tag;
        logic [GW-1:0]    gran;
    } entry_t;

    typedef struct packed {
        entry_t [ENTRIES-1:0] ent;
        logic [IDX_W-1:0]     ptr;
        logic                 done;
        logic                 hit;
    } state_t;

    state_t state_d, state_q;

    logic [GW-1:0] alloc_gran, store_gran;
    assign alloc_gran = alloc_addr_i[ADDR_W-1:GRAN_LSB];
    assign store_gran = store_addr_i[ADDR_W-1:GRAN_LSB];

    logic unused_lsbs;
    assign unused_lsbs = ^{alloc_addr_i[GRAN_LSB-1:0], store_addr_i[GRAN_LSB-1:0]};

    logic [ENTRIES-1:0]            vld_q;
    logic [ENTRIES-1:0][TAG_W-1:0] tags_q;
    logic [ENTRIES-1:0][GW-1:0]    grans_q;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            vld_q[i]   = state_q.ent[i].v;
            tags_q[i]  = state_q.ent[i].tag;
            grans_q[i] = state_q.ent[i].gran;
        end
    end

    logic [ENTRIES-1:0] kill_vec, same_vec, chk_vec, live_vec;
    logic [IDX_W-1:0]   vict_idx;
    logic               vict_use_ptr;

    slt_match #(.N(ENTRIES), .TAG_W(TAG_W), .GW(GW)) u_match (
        .valid_i      (vld_q),
        .tags_i       (tags_q),
        .grans_i      (grans_q),
        .store_gran_i (store_gran),
        .alloc_tag_i  (alloc_tag_i),
        .chk_tag_i    (chk_tag_i),
        .kill_o       (kill_vec),
        .alloc_same_o (same_vec),
        .chk_vec_o    (chk_vec)
    );

    // store is ordered ahead of the allocate in the same cycle
    assign live_vec = store_valid_i ? (vld_q & ~kill_vec) : vld_q;

    slt_victim #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .live_i    (live_vec),
        .same_i    (same_vec),
        .ptr_i     (state_q.ptr),
        .idx_o     (vict_idx),
        .use_ptr_o (vict_use_ptr)
    );

    always_comb begin
        state_d      = state_q;
        state_d.done = chk_valid_i;
        state_d.hit  = chk_valid_i && (|chk_vec);
        for (int i = 0; i < ENTRIES; i++) begin
            state_d.ent[i].v = live_vec[i];
        end
        if (alloc_valid_i && !flush_i) begin
            state_d.ent[vict_idx].v    = 1'b1;
            state_d.ent[vict_idx].tag  = alloc_tag_i;
            state_d.ent[vict_idx].gran = alloc_gran;
            if (vict_use_ptr) begin
                state_d.ptr = (state_q.ptr == IDX_W'(ENTRIES - 1)) ? '0 : state_q.ptr + 1'b1;
            end
        end
        if (flush_i) begin
            for (int i = 0; i < ENTRIES; i++) begin
                state_d.ent[i].v = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign chk_done_o = state_q.done;
    assign chk_hit_o  = state_q.hit;

    function automatic logic tag_present(input logic [TAG_W-1:0] t);
        logic r;
        r = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (state_q.ent[i].v && state_q.ent[i].tag == t) r = 1'b1;
        end
        return r;
    endfunction

    function automatic logic gran_present(input logic [GW-1:0] g);
        logic r;
        r = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (state_q.ent[i].v && state_q.ent[i].gran == g) r = 1'b1;
        end
        return r;
    endfunction

    assert_alloc_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && !flush_i) |=> tag_present($past(alloc_tag_i)));

    assert_resp_next_R3: assert property (@(posedge clk) disable iff (!rst_n)
        chk_valid_i |=> chk_done_o);

    assert_no_idle_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !chk_valid_i |=> !chk_done_o);

    assert_store_kills_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (store_valid_i && !flush_i && !(alloc_valid_i && alloc_gran == store_gran))
        |=> !gran_present($past(store_gran)));

    assert_tag_unique_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chk_vec));

    assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (vld_q == '0));

    assert_alloc_survives_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_valid_i && store_valid_i && !flush_i && alloc_gran == store_gran)
        |=> gran_present($past(alloc_gran)));
endmodule

// File: tb/tb_spec_load_tracker.sv
module tb_spec_load_tracker;
    localparam int N = 16;
    localparam int TW = 7;
    localparam int AW = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_i = 1'b0;
    logic alloc_valid_i = 1'b0;
    logic [TW-1:0] alloc_tag_i = '0;
    logic [AW-1:0] alloc_addr_i = '0;
    logic store_valid_i = 1'b0;
    logic [AW-1:0] store_addr_i = '0;
    logic chk_valid_i = 1'b0;
    logic [TW-1:0] chk_tag_i = '0;
    logic chk_done_o, chk_hit_o;

    always #4 clk = ~clk;

    spec_load_tracker dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .alloc_valid_i(alloc_valid_i), .alloc_tag_i(alloc_tag_i), .alloc_addr_i(alloc_addr_i),
        .store_valid_i(store_valid_i), .store_addr_i(store_addr_i),
        .chk_valid_i(chk_valid_i), .chk_tag_i(chk_tag_i),
        .chk_done_o(chk_done_o), .chk_hit_o(chk_hit_o)
    );

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    // behavioural reference state
    bit        m_v[N];
    int        m_t[N];
    longint    m_g[N];
    int        m_p;

    task automatic fail(string req, string what, int act, int exp);
        errors++;
        $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    endtask

    task automatic model_reset();
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_t[i] = 0; m_g[i] = 0; end
        m_p = 0;
    endtask

    // one cycle of stimulus; want: -1 none, else expected hit for the check
    task automatic step(bit fl, bit av, int at, longint aa, bit sv, longint sa,
                        bit cv, int ct, int want, string req);
        bit exp_hit;
        bit live[N];
        int idx;
        @(negedge clk);
        flush_i = fl; alloc_valid_i = av; alloc_tag_i = TW'(at); alloc_addr_i = AW'(aa);
        store_valid_i = sv; store_addr_i = AW'(sa); chk_valid_i = cv; chk_tag_i = TW'(ct);
        @(posedge clk);
        exp_hit = 0;
        for (int i = 0; i < N; i++) if (m_v[i] && m_t[i] == ct) exp_hit = 1;
        for (int i = 0; i < N; i++) live[i] = m_v[i] && !(sv && m_g[i] == (sa >>> 3));
        if (av && !fl) begin
            idx = -1;
            for (int i = 0; i < N; i++) if (idx < 0 && live[i] && m_t[i] == at) idx = i;
            for (int i = 0; i < N; i++) if (idx < 0 && !live[i]) idx = i;
            if (idx < 0) begin idx = m_p; m_p = (m_p + 1) % N; end
            live[idx] = 1; m_t[idx] = at; m_g[idx] = aa >>> 3;
        end
        for (int i = 0; i < N; i++) m_v[i] = fl ? 0 : live[i];
        #2;
        checks++;
        if (chk_done_o !== cv) fail(req, "chk_done", int'(chk_done_o), int'(cv));
        if (cv) begin
            checks++;
            if (chk_hit_o !== exp_hit) fail(req, "chk_hit vs model", int'(chk_hit_o), int'(exp_hit));
            if (want >= 0) begin
                checks++;
                if (chk_hit_o !== want[0]) fail(req, "chk_hit directed", int'(chk_hit_o), want);
            end
        end
    endtask

    task automatic alloc(int t, longint a, string req);
        step(0, 1, t, a, 0, 0, 0, 0, -1, req);
    endtask
    task automatic store(longint a, string req);
        step(0, 0, 0, 0, 1, a, 0, 0, -1, req);
    endtask
    task automatic chk(int t, int want, string req);
        step(0, 0, 0, 0, 0, 0, 1, t, want, req);
    endtask
    task automatic idle(string req);
        step(0, 0, 0, 0, 0, 0, 0, 0, -1, req);
    endtask

    initial begin
        #1600000;
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
        if (!finished) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        checks++;
        if (chk_done_o !== 1'b0) fail("R1", "chk_done after reset", int'(chk_done_o), 0);
        chk(3, 0, "R1");
        chk(3, 0, "R11");
        // R2 / R6
        alloc(3, 64'h1000, "R2");
        chk(3, 1, "R2");
        chk(3, 1, "R6");
        chk(9, 0, "R11");
        // R4 / R5: two registers in one granule, one elsewhere
        alloc(4, 64'h1004, "R4");
        alloc(5, 64'h2000, "R4");
        store(64'h1007, "R5");
        chk(3, 0, "R4");
        chk(4, 0, "R4");
        chk(5, 1, "R4");
        alloc(6, 64'h3000, "R5");
        store(64'h3008, "R5");
        chk(6, 1, "R5");
        // R3: check sees table before same-cycle store
        step(0, 0, 0, 0, 1, 64'h2000, 1, 5, 1, "R3");
        chk(5, 0, "R3");
        // R7: replace tag 6 address
        alloc(6, 64'h4000, "R7");
        store(64'h3000, "R7");
        chk(6, 1, "R7");
        store(64'h4000, "R7");
        chk(6, 0, "R7");
        // R10: same-cycle allocate and store
        step(0, 1, 7, 64'h5000, 1, 64'h5003, 0, 0, -1, "R10");
        chk(7, 1, "R10");
        // R9: flush, and flush beats allocate
        step(1, 0, 0, 0, 0, 0, 0, 0, -1, "R9");
        chk(7, 0, "R9");
        step(1, 1, 8, 64'h6000, 0, 0, 0, 0, -1, "R9");
        chk(8, 0, "R9");
        // R8: fill, evict round robin, reuse freed slot
        for (int i = 0; i < N; i++) alloc(10 + i, 64'(10 + i) * 64'h100, "R8");
        chk(10, 1, "R8");
        alloc(30, 64'h9000, "R8");
        chk(10, 0, "R8");
        chk(30, 1, "R8");
        chk(11, 1, "R8");
        alloc(31, 64'h9100, "R8");
        chk(11, 0, "R8");
        store(64'(15) * 64'h100, "R8");
        alloc(32, 64'h9200, "R8");
        chk(12, 1, "R8");
        chk(32, 1, "R8");
        chk(15, 0, "R8");
        // random traffic against the model
        for (int k = 0; k < 3000; k++) begin
            step(($urandom % 97) == 0, $urandom % 2, $urandom % 24,
                 longint'($urandom % 64) * 4, $urandom % 3 == 0, longint'($urandom % 64) * 4,
                 $urandom % 2, $urandom % 24, -1, "R8");
        end
        idle("R3");
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule